// File: doc/BRIEF.md
# Single-Transfer Bus Master Controller

This block lets a local agent make one read or one write on a shared, arbitrated, pipelined bus. A one-cycle start strobe hands over an address, a direction flag and, for writes, the data to send. The controller then raises its bus request and waits. When it samples its grant (with the bus ready), it drops the request and issues exactly one non-sequential transfer of burst type single. It then drives the data phase and reports completion with a one-cycle done strobe, returning read data for reads.

The arbiter only sees the dropped request one or two edges later, so the grant can stay on for cycles the controller no longer needs. In every one of those cycles the controller drives the IDLE transfer type with address zero. It does not leave the bus undriven or release it early. When the grant falls, the controller returns to its idle state and can take a new start.

Top module: `bus_single_master`

## Requirements
- R1: After reset, busReq is 0, busTrans is IDLE (2'b00), busAddr is 0, busWrite is 0, busy is 0 and donePulse is 0.
- R2: A start strobe seen while idle is accepted at that edge; busReq is 1 from the next cycle and stays 1 on every cycle until an edge samples busGrant and busReady both high.
- R3: On the edge that samples busGrant and busReady high during the request, busReq falls. In the next cycle the controller drives busTrans = NONSEQ (2'b10), busBurst = SINGLE (3'b000), the stored address and the stored write flag. Exactly one NONSEQ is issued per accepted start.
- R4: While busReady is low during the address phase, busTrans stays NONSEQ and busAddr and busWrite hold their values.
- R5: In the cycle after the address phase is accepted (busReady high), the data phase runs. busTrans is IDLE and busAddr is 0, and busWdata carries the stored write data for a write (0 for a read).
- R6: At the edge where busReady is high in the data phase, a read captures busRdata into rdData. donePulse is 1 for exactly the next cycle. A data phase with busReady low extends by a cycle without a done strobe.
- R7: After the data phase, for every cycle in which busGrant stays high, busTrans is IDLE and busAddr is 0. When busGrant is sampled low, the controller returns to idle.
- R8: busy is 1 from the cycle after a start is accepted until the controller is idle again. A start strobe while busy is ignored: no new request appears after the controller goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | One-cycle request to perform a transfer |
| startAddr | input | ADDR_W | Target address of the transfer |
| startWrite | input | 1 | 1 = write, 0 = read |
| startWdata | input | DATA_W | Data to write |
| busy | output | 1 | Transfer in progress; starts are ignored |
| donePulse | output | 1 | One-cycle completion strobe |
| rdData | output | DATA_W | Last captured read data |
| busReq | output | 1 | Bus request to the arbiter |
| busGrant | input | 1 | Grant from the arbiter |
| busReady | input | 1 | Bus ready / transfer accept |
| busTrans | output | 2 | Transfer type: 2'b00 IDLE, 2'b10 NONSEQ |
| busAddr | output | ADDR_W | Address |
| busWrite | output | 1 | Write flag of the address phase |
| busBurst | output | 3 | Burst type, always SINGLE (3'b000) |
| busSize | output | 3 | Transfer size, log2 of bytes per word |
| busWdata | output | DATA_W | Write data in the data phase |
| busRdata | input | DATA_W | Read data from the bus |

## Verification
The bench builds the block with ADDR_W = 20 and DATA_W = 32. With a narrower address, a pattern with the top address bit set checks that the whole field reaches busAddr and that a zero address is not produced by truncation. Full 32-bit data words with both halves nonzero check the write path and the read capture end to end. The arbiter model holds the grant for one, several and zero extra cycles, and adds busReady stalls in both the address and data phases, so that the parked-IDLE run and the stall holds are each exercised.

// File: rtl/sxm_pkg.sv
package sxm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA,
    ST_PARK
  } sxmState_e;

  typedef struct packed {
    logic load;       // latch start arguments
    logic driveAddr;  // address phase on the bus
    logic driveData;  // data phase on the bus
    logic capture;    // data phase completes this edge
  } sxmStrobe_t;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [2:0] BURST_SINGLE = 3'b000;
endpackage

// File: rtl/sxm_ctrl.sv
module sxm_ctrl
  import sxm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       busGrant,
  input  logic       busReady,
  output sxmStrobe_t strobes,
  output logic       busReq,
  output logic       busy,
  output logic       donePulse
);
  sxmState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startPulse)           stateNext = ST_REQ;
      ST_REQ:  if (busGrant && busReady) stateNext = ST_ADDR;
      ST_ADDR: if (busReady)             stateNext = ST_DATA;
      ST_DATA: if (busReady)             stateNext = busGrant ? ST_PARK : ST_IDLE;
      ST_PARK: if (!busGrant)            stateNext = ST_IDLE;
      default:                           stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      donePulse <= 1'b0;
    end else begin
      state     <= stateNext;
      donePulse <= (state == ST_DATA) && busReady;
    end
  end

  always_comb begin
    strobes.load      = (state == ST_IDLE) && startPulse;
    strobes.driveAddr = (state == ST_ADDR);
    strobes.driveData = (state == ST_DATA);
    strobes.capture   = (state == ST_DATA) && busReady;
  end

  assign busReq = (state == ST_REQ);
  assign busy   = (state != ST_IDLE);

  // R2: request persists until grant and ready are sampled together
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !(busGrant && busReady) |=> busReq);

  // R3: request removed on the grant edge
  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busGrant && busReady |=> !busReq && strobes.driveAddr);

  // R8: parked state never restarts a request directly
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_PARK |=> !busReq);
endmodule

// File: rtl/sxm_datapath.sv
module sxm_datapath
  import sxm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  sxmStrobe_t        strobes,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              startWrite,
  input  logic [DATA_W-1:0] startWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busTrans,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rdData
);
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic              writeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      writeReg <= 1'b0;
      rdData   <= '0;
    end else begin
      if (strobes.load) begin
        addrReg  <= startAddr;
        wdataReg <= startWdata;
        writeReg <= startWrite;
      end
      if (strobes.capture && !writeReg) rdData <= busRdata;
    end
  end

  assign busAddr  = strobes.driveAddr ? addrReg : '0;
  assign busTrans = strobes.driveAddr ? TRANS_NONSEQ : TRANS_IDLE;
  assign busWrite = strobes.driveAddr && writeReg;
  assign busWdata = (strobes.driveData && writeReg) ? wdataReg : '0;

  // R5: write data only appears outside the address phase
  p_wdata_phase_r5: assert property (@(posedge clk) disable iff (!rstN)
    busWdata != '0 |-> busTrans == TRANS_IDLE);
endmodule

// File: rtl/bus_single_master.sv
module bus_single_master
  import sxm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              startWrite,
  input  logic [DATA_W-1:0] startWdata,
  output logic              busy,
  output logic              donePulse,
  output logic [DATA_W-1:0] rdData,
  output logic              busReq,
  input  logic              busGrant,
  input  logic              busReady,
  output logic [1:0]        busTrans,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic [2:0]        busBurst,
  output logic [2:0]        busSize,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata
);
  localparam int SIZE_CODE = $clog2(DATA_W / 8);

  sxmStrobe_t strobes;

  sxm_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .busGrant  (busGrant),
    .busReady  (busReady),
    .strobes   (strobes),
    .busReq    (busReq),
    .busy      (busy),
    .donePulse (donePulse)
  );

  sxm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .startAddr (startAddr),
    .startWrite(startWrite),
    .startWdata(startWdata),
    .busRdata  (busRdata),
    .busAddr   (busAddr),
    .busTrans  (busTrans),
    .busWrite  (busWrite),
    .busWdata  (busWdata),
    .rdData    (rdData)
  );

  assign busBurst = BURST_SINGLE;
  assign busSize  = 3'(SIZE_CODE);

  // R3: a NONSEQ accepted by ready is followed by IDLE
  p_nonseq_once_r3: assert property (@(posedge clk) disable iff (!rstN)
    busTrans == TRANS_NONSEQ && busReady |=> busTrans == TRANS_IDLE);

  // R4: stalled address phase holds
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    busTrans == TRANS_NONSEQ && !busReady |=>
      busTrans == TRANS_NONSEQ && $stable(busAddr) && $stable(busWrite));

  // R7: every IDLE cycle carries a zero address
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    busTrans == TRANS_IDLE |-> busAddr == '0);

  // R6: completion strobe lasts a single cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R3: only the two legal transfer codes ever appear
  p_trans_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    busTrans == TRANS_IDLE || busTrans == TRANS_NONSEQ);
endmodule

// File: tb/bus_single_master_tb_top.sv
module bus_single_master_tb_top;
  localparam int AW = 20;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic startWrite = 1'b0;
  logic [DW-1:0] startWdata = '0;
  logic busy, donePulse, busReq, busWrite;
  logic [DW-1:0] rdData, busWdata;
  logic busGrant = 1'b0;
  logic busReady = 1'b1;
  logic [1:0] busTrans;
  logic [AW-1:0] busAddr;
  logic [2:0] busBurst, busSize;
  logic [DW-1:0] busRdata = '0;

  int nTests = 0;
  int nFail  = 0;

  always #4 clk = ~clk;  // 125 MHz

  bus_single_master #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startAddr(startAddr),
    .startWrite(startWrite), .startWdata(startWdata), .busy(busy),
    .donePulse(donePulse), .rdData(rdData), .busReq(busReq),
    .busGrant(busGrant), .busReady(busReady), .busTrans(busTrans),
    .busAddr(busAddr), .busWrite(busWrite), .busBurst(busBurst),
    .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic test_reset();
    tick();
    chk("R1 busReq", busReq, 0);
    chk("R1 busTrans", busTrans, 2'b00);
    chk("R1 busAddr", busAddr, 0);
    chk("R1 busWrite", busWrite, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", donePulse, 0);
  endtask

  // Write, grant late by one cycle, two parked cycles
  task automatic test_write_park();
    startPulse = 1; startAddr = 20'h8_1234; startWrite = 1; startWdata = 32'hA5C3_0F1E;
    tick(); startPulse = 0;
    chk("R2 req after start", busReq, 1);
    chk("R8 busy after start", busy, 1);
    tick();
    chk("R2 req held no grant", busReq, 1);
    busGrant = 1; busReady = 1;
    tick();
    chk("R3 req dropped", busReq, 0);
    chk("R3 NONSEQ", busTrans, 2'b10);
    chk("R3 addr", busAddr, 20'h8_1234);
    chk("R3 write flag", busWrite, 1);
    chk("R3 burst single", busBurst, 3'b000);
    chk("R3 size", busSize, 3'd2);
    tick();
    chk("R5 data trans idle", busTrans, 2'b00);
    chk("R5 data addr zero", busAddr, 0);
    chk("R5 wdata", busWdata, 32'hA5C3_0F1E);
    chk("R6 no done yet", donePulse, 0);
    tick();
    chk("R6 done", donePulse, 1);
    chk("R7 park idle", busTrans, 2'b00);
    chk("R7 park addr", busAddr, 0);
    chk("R8 busy in park", busy, 1);
    tick();
    chk("R6 done single", donePulse, 0);
    chk("R7 park idle 2", busTrans, 2'b00);
    chk("R3 no second req", busReq, 0);
    busGrant = 0;
    tick();
    chk("R7 back idle", busy, 0);
  endtask

  // Read with address-phase and data-phase stalls, grant dropped in data phase
  task automatic test_read_stall();
    busReady = 0; busGrant = 1;
    startPulse = 1; startAddr = 20'h0_00F0; startWrite = 0; startWdata = 32'hFFFF_FFFF;
    tick(); startPulse = 0;
    chk("R2 req", busReq, 1);
    tick();
    chk("R2 req held ready low", busReq, 1);
    busReady = 1;
    tick();
    chk("R3 NONSEQ read", busTrans, 2'b10);
    chk("R3 read flag", busWrite, 0);
    busReady = 0;
    tick();
    chk("R4 held trans", busTrans, 2'b10);
    chk("R4 held addr", busAddr, 20'h0_00F0);
    busReady = 1;
    tick();
    chk("R5 read wdata zero", busWdata, 0);
    busReady = 0; busGrant = 0;
    tick();
    chk("R6 stalled no done", donePulse, 0);
    chk("R5 still data idle", busTrans, 2'b00);
    busReady = 1; busRdata = 32'h1357_9BDF;
    tick();
    busRdata = 0;
    chk("R6 done read", donePulse, 1);
    chk("R6 rdData", rdData, 32'h1357_9BDF);
    chk("R7 idle no grant", busy, 0);
  endtask

  // Start while busy is ignored
  task automatic test_busy_ignore();
    busGrant = 0; busReady = 1;
    startPulse = 1; startAddr = 20'h7_0001; startWrite = 1; startWdata = 32'h1;
    tick(); startPulse = 0;
    busGrant = 1;
    tick(); tick(); tick();
    chk("R8 parked busy", busy, 1);
    startPulse = 1; startAddr = 20'h2_2222;
    tick(); startPulse = 0;
    busGrant = 0;
    tick();
    chk("R8 idle after park", busy, 0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R8 ignored start no req", busReq, 0);
    end
  endtask

  initial begin
    fork
      begin
        #2000000;
        nTests++; nFail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
      begin
        repeat (3) tick();
        rstN = 1;
        test_reset();
        test_write_park();
        test_read_stall();
        test_busy_ignore();
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule